// File: doc/BRIEF.md
# Video Processor Host Access Sequencer

This block converts single host requests into the chip-select strobe sequences an 8-bit external video display processor expects on its two ports: a data port for video memory bytes and a control port that takes address setup bytes, register writes and status reads. Each request becomes a short series of one-byte strobes. The block holds every strobe for a set width, waits a recovery gap after each strobe (short after a control-port access, long after a data-port access), and drives the device reset pulse once after system reset.

The block tracks two device settings from the register writes it issues itself. Register 25 bit 2 enables the device's wait output, and while that bit is set a low `vdp_wait_n` stretches the active strobe. When `guard_en` is high, a user-mode write that clears the interrupt-enable bit of register 1 cannot be stopped, because the value byte goes out first. The block therefore appends a second register write that sets that bit again, before it takes the next request.

All timings are parameters in nanoseconds and are converted to clock cycles from the clock frequency parameter. The names STROBE_C, SHORT_C, LONG_C and RESET_C below are those cycle counts.

Top module: `vdp_host_seq`

## Requirements
- R1: After `rst_n` is released, `vdp_reset_n` stays low and rises on the RESET_C-th rising clock edge. While it is low, no strobe is driven and `req_ready` is low.
- R2: A VRAM write (`req_op`=0) drives three write strobes in this order: control port `req_addr[7:0]`, control port {2'b01, `req_addr[13:8]`}, then data port `req_data`. `vdp_mode` is 1 for the control port and 0 for the data port.
- R3: A VRAM read (`req_op`=1) drives two control-port writes, `req_addr[7:0]` then {2'b00, `req_addr[13:8]`}, followed by one data-port read strobe. The byte on `vdp_din` in the last strobe cycle appears on `rd_data` with `rd_valid` high in the following cycle.
- R4: A register write (`req_op`=2) drives two control-port write strobes: first `req_data`, then {2'b10, `req_addr[5:0]`}.
- R5: A status read (`req_op`=3) drives exactly one read strobe on the control port and no write strobe, and returns the sampled byte as in R3.
- R6: Each strobe lasts STROBE_C cycles when it is not stretched, and `vdp_csw_n` and `vdp_csr_n` are never low together.
- R7: After a control-port strobe the block stays idle on the device side for SHORT_C cycles, and after a data-port strobe for LONG_C cycles, before the next strobe or before `req_ready` returns.
- R8: `req_ready` is high only when no sequence, gap or reset pulse is in progress. A request is taken only in a cycle where both `req_valid` and `req_ready` are high.
- R9: The wait enable follows bit 2 of the last value this block wrote to register 25. It is updated when the second strobe of that register write ends and is cleared by reset. While it is set and `vdp_wait_n` is low, the active strobe and its byte are held. While it is clear, `vdp_wait_n` has no effect.
- R10: When `guard_en` and `req_user` are high and a register write targets register 1 with bit 5 of the value clear, a second write of (value | 8'h20) to register 1 (bytes value|8'h20, then 8'h81) follows the first one's gap, before `req_ready` returns. No such write is added when `req_user` is low, when `guard_en` is low, or when bit 5 is already set.
- R11: `rd_valid` pulses for exactly one cycle per read strobe and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| guard_en | input | 1 | Enables restoring the interrupt-enable bit after user writes |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can take a request |
| req_op | input | 2 | 0 VRAM write, 1 VRAM read, 2 register write, 3 status read |
| req_user | input | 1 | Request comes from user mode |
| req_addr | input | 14 | VRAM address; bits 5:0 give the register number for register writes |
| req_data | input | 8 | Write byte or register value |
| rd_valid | output | 1 | One-cycle pulse when read data is returned |
| rd_data | output | 8 | Byte returned by a read |
| vdp_csw_n | output | 1 | Device write strobe, active low |
| vdp_csr_n | output | 1 | Device read strobe, active low |
| vdp_mode | output | 1 | Port select: 1 control port, 0 data port |
| vdp_dout | output | 8 | Byte driven to the device |
| vdp_din | input | 8 | Byte from the device |
| vdp_wait_n | input | 1 | Device wait, active low |
| vdp_reset_n | output | 1 | Device reset, active low |

## Verification
The checker watches, on every cycle, that the two strobes are never low together, that no strobe or ready appears during the reset pulse, that a strobe is released for at least one cycle before another starts, that read data follows a read strobe as a single pulse, and that an enabled wait freezes the strobe and its byte. The exact byte order of each request type, the strobe widths, the two gap lengths, the wait enable taking effect from a register 25 write, and the extra restore write in guard mode depend on sequences of requests. Only the bench's reference model and its device model can show those.

// File: rtl/vdp_seq_pkg.sv
package vdp_seq_pkg;

    localparam int VADDR_W  = 14;
    localparam int REG_W    = 6;
    localparam int SEQ_N    = 4;
    localparam int IE_REG   = 1;
    localparam int IE_BIT   = 5;
    localparam int WAIT_REG = 25;
    localparam int WAIT_BIT = 2;

    typedef enum logic [1:0] {
        OP_VRAM_WR = 2'd0,
        OP_VRAM_RD = 2'd1,
        OP_REG_WR  = 2'd2,
        OP_STATUS  = 2'd3
    } host_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_GAP    = 2'd2
    } seq_state_e;

    typedef logic [SEQ_N-1:0][7:0] seq_bytes_t;

    // nanoseconds to clock cycles, rounded up, never below one
    function automatic int ns_to_cycles(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/vdp_reset_pulse.sv
module vdp_reset_pulse #(
    parameter int PULSE_C = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic dev_reset_n
);
    localparam int CW = $clog2(PULSE_C + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } rp_t;

    rp_t rp_d, rp_q;

    always_comb begin
        rp_d = rp_q;
        if (!rp_q.done) begin
            if (rp_q.cnt == CW'(PULSE_C - 1)) begin
                rp_d.done = 1'b1;
            end else begin
                rp_d.cnt = rp_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    assign dev_reset_n = rp_q.done;

endmodule

// File: rtl/vdp_req_encode.sv
module vdp_req_encode
    import vdp_seq_pkg::*;
(
    input  host_op_e             op,
    input  logic [VADDR_W-1:0]   addr,
    input  logic [7:0]           data,
    output seq_bytes_t           bytes,
    output logic [SEQ_N-1:0]     to_ctl,
    output logic [SEQ_N-1:0]     is_rd,
    output logic [1:0]           last
);
    always_comb begin
        bytes  = '0;
        to_ctl = '0;
        is_rd  = '0;
        last   = 2'd0;
        unique case (op)
            OP_VRAM_WR: begin
                bytes[0] = addr[7:0];
                bytes[1] = {2'b01, addr[13:8]};
                bytes[2] = data;
                to_ctl   = 4'b0011;
                last     = 2'd2;
            end
            OP_VRAM_RD: begin
                bytes[0] = addr[7:0];
                bytes[1] = {2'b00, addr[13:8]};
                to_ctl   = 4'b0011;
                is_rd    = 4'b0100;
                last     = 2'd2;
            end
            OP_REG_WR: begin
                bytes[0] = data;
                bytes[1] = {2'b10, addr[REG_W-1:0]};
                to_ctl   = 4'b0011;
                last     = 2'd1;
            end
            default: begin
                to_ctl   = 4'b0001;
                is_rd    = 4'b0001;
                last     = 2'd0;
            end
        endcase
    end

endmodule

// File: rtl/vdp_reg_snoop.sv
module vdp_reg_snoop
    import vdp_seq_pkg::*;
(
    input  logic             guard_en,
    input  logic             user,
    input  host_op_e         op,
    input  logic [REG_W-1:0] reg_sel,
    input  logic [7:0]       data,
    output logic             set_wait,
    output logic             need_fix,
    output logic [7:0]       fix_val
);
    logic is_reg;

    always_comb begin
        is_reg   = (op == OP_REG_WR);
        set_wait = is_reg && (reg_sel == REG_W'(WAIT_REG));
        need_fix = guard_en && user && is_reg
                   && (reg_sel == REG_W'(IE_REG)) && !data[IE_BIT];
        fix_val  = data | (8'h01 << IE_BIT);
    end

endmodule

// File: rtl/vdp_host_seq.sv
module vdp_host_seq
    import vdp_seq_pkg::*;
#(
    parameter int CLK_MHZ      = 100,
    parameter int STROBE_NS    = 200,
    parameter int SHORT_GAP_NS = 2000,
    parameter int LONG_GAP_NS  = 8000,
    parameter int RESET_NS     = 10000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         guard_en,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [1:0]   req_op,
    input  logic         req_user,
    input  logic [13:0]  req_addr,
    input  logic [7:0]   req_data,
    output logic         rd_valid,
    output logic [7:0]   rd_data,
    output logic         vdp_csw_n,
    output logic         vdp_csr_n,
    output logic         vdp_mode,
    output logic [7:0]   vdp_dout,
    input  logic [7:0]   vdp_din,
    input  logic         vdp_wait_n,
    output logic         vdp_reset_n
);
    localparam int STROBE_C = ns_to_cycles(STROBE_NS, CLK_MHZ);
    localparam int SHORT_C  = ns_to_cycles(SHORT_GAP_NS, CLK_MHZ);
    localparam int LONG_C   = ns_to_cycles(LONG_GAP_NS, CLK_MHZ);
    localparam int RESET_C  = ns_to_cycles(RESET_NS, CLK_MHZ);
    localparam int MAX_C    = (STROBE_C > SHORT_C)
                              ? ((STROBE_C > LONG_C) ? STROBE_C : LONG_C)
                              : ((SHORT_C > LONG_C) ? SHORT_C : LONG_C);
    localparam int CNT_W    = $clog2(MAX_C + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [1:0]       idx;
        logic [1:0]       last;
        seq_bytes_t       bytes;
        logic [SEQ_N-1:0] to_ctl;
        logic [SEQ_N-1:0] is_rd;
        logic [CNT_W-1:0] cnt;
        logic             set_wait;
        logic             wait_en;
        logic             fix_pend;
        logic [7:0]       fix_val;
        logic             rd_valid;
        logic [7:0]       rd_data;
    } seq_t;

    seq_t q, d;

    host_op_e         op;
    seq_bytes_t       enc_bytes;
    logic [SEQ_N-1:0] enc_ctl;
    logic [SEQ_N-1:0] enc_rd;
    logic [1:0]       enc_last;
    logic             snp_set_wait;
    logic             snp_need_fix;
    logic [7:0]       snp_fix_val;
    logic             rst_done;
    logic             accept;
    logic             hold;
    logic             strobe_on;
    logic             wait_en_w;

    assign op = host_op_e'(req_op);

    vdp_reset_pulse #(.PULSE_C(RESET_C)) u_rst (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_reset_n (rst_done)
    );

    vdp_req_encode u_enc (
        .op     (op),
        .addr   (req_addr),
        .data   (req_data),
        .bytes  (enc_bytes),
        .to_ctl (enc_ctl),
        .is_rd  (enc_rd),
        .last   (enc_last)
    );

    vdp_reg_snoop u_snp (
        .guard_en (guard_en),
        .user     (req_user),
        .op       (op),
        .reg_sel  (req_addr[REG_W-1:0]),
        .data     (req_data),
        .set_wait (snp_set_wait),
        .need_fix (snp_need_fix),
        .fix_val  (snp_fix_val)
    );

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        accept     = req_valid && req_ready;
        hold       = q.wait_en && !vdp_wait_n;
        unique case (q.st)
            ST_IDLE: begin
                if (accept) begin
                    d.st       = ST_STROBE;
                    d.idx      = 2'd0;
                    d.last     = enc_last;
                    d.bytes    = enc_bytes;
                    d.to_ctl   = enc_ctl;
                    d.is_rd    = enc_rd;
                    d.cnt      = CNT_W'(STROBE_C - 1);
                    d.set_wait = snp_set_wait;
                    d.fix_pend = snp_need_fix;
                    d.fix_val  = snp_fix_val;
                end
            end
            ST_STROBE: begin
                if (!hold) begin
                    if (q.cnt == '0) begin
                        d.st  = ST_GAP;
                        d.cnt = q.to_ctl[q.idx] ? CNT_W'(SHORT_C - 1)
                                                : CNT_W'(LONG_C - 1);
                        if (q.is_rd[q.idx]) begin
                            d.rd_valid = 1'b1;
                            d.rd_data  = vdp_din;
                        end
                        if (q.set_wait && (q.idx == 2'd1)) begin
                            d.wait_en = q.bytes[0][WAIT_BIT];
                        end
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (q.cnt == '0) begin
                    if (q.idx != q.last) begin
                        d.idx = q.idx + 1'b1;
                        d.st  = ST_STROBE;
                        d.cnt = CNT_W'(STROBE_C - 1);
                    end else if (q.fix_pend) begin
                        d.st       = ST_STROBE;
                        d.idx      = 2'd0;
                        d.last     = 2'd1;
                        d.bytes    = '0;
                        d.bytes[0] = q.fix_val;
                        d.bytes[1] = {2'b10, REG_W'(IE_REG)};
                        d.to_ctl   = 4'b0011;
                        d.is_rd    = '0;
                        d.cnt      = CNT_W'(STROBE_C - 1);
                        d.set_wait = 1'b0;
                        d.fix_pend = 1'b0;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign strobe_on   = (q.st == ST_STROBE);
    assign req_ready   = (q.st == ST_IDLE) && rst_done;
    assign vdp_csw_n   = !(strobe_on && !q.is_rd[q.idx]);
    assign vdp_csr_n   = !(strobe_on && q.is_rd[q.idx]);
    assign vdp_mode    = q.to_ctl[q.idx];
    assign vdp_dout    = q.bytes[q.idx];
    assign rd_valid    = q.rd_valid;
    assign rd_data     = q.rd_data;
    assign vdp_reset_n = rst_done;
    assign wait_en_w   = q.wait_en;

endmodule

// File: rtl/vdp_host_seq_chk.sv
module vdp_host_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rd_valid,
    input logic       vdp_csw_n,
    input logic       vdp_csr_n,
    input logic [7:0] vdp_dout,
    input logic       vdp_wait_n,
    input logic       vdp_reset_n,
    input logic       wait_en
);
    // R6: the two strobes never overlap
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!vdp_csw_n && !vdp_csr_n));

    // R1: nothing reaches the device while its reset is low
    a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !vdp_reset_n |-> (vdp_csw_n && vdp_csr_n && !req_ready));

    // R8: ready is never offered while a strobe is active
    a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (vdp_csw_n && vdp_csr_n));

    // R7: a released write strobe is followed by at least one gap cycle
    a_r7_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vdp_csw_n) |-> (vdp_csw_n && vdp_csr_n));

    // R3: returned data follows a read strobe
    a_r3_rd_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!vdp_csr_n));

    // R11: read data valid is a single-cycle pulse
    a_r11_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R9: an enabled, asserted wait freezes the write strobe and its byte
    a_r9_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!vdp_csw_n && wait_en && !vdp_wait_n) |=> (!vdp_csw_n && $stable(vdp_dout)));

endmodule

bind vdp_host_seq vdp_host_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .vdp_csw_n   (vdp_csw_n),
    .vdp_csr_n   (vdp_csr_n),
    .vdp_dout    (vdp_dout),
    .vdp_wait_n  (vdp_wait_n),
    .vdp_reset_n (vdp_reset_n),
    .wait_en     (wait_en_w)
);

// File: tb/vdp_host_seq_tb_top.sv
module vdp_host_seq_tb_top;

    // cycle counts implied by the parameters below at 250 MHz
    localparam int STROBE_C = 3;
    localparam int SHORT_C  = 10;
    localparam int LONG_C   = 30;
    localparam int RESET_C  = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       guard_en = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_op = 2'd0;
    logic       req_user = 1'b0;
    logic [13:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       vdp_csw_n, vdp_csr_n, vdp_mode;
    logic [7:0] vdp_dout;
    logic [7:0] vdp_din = 8'h00;
    logic       vdp_wait_n = 1'b1;
    logic       vdp_reset_n;

    always #2 clk = ~clk;

    vdp_host_seq #(
        .CLK_MHZ(250), .STROBE_NS(12), .SHORT_GAP_NS(40),
        .LONG_GAP_NS(120), .RESET_NS(200)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .guard_en(guard_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_user(req_user), .req_addr(req_addr), .req_data(req_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .vdp_csw_n(vdp_csw_n), .vdp_csr_n(vdp_csr_n), .vdp_mode(vdp_mode),
        .vdp_dout(vdp_dout), .vdp_din(vdp_din), .vdp_wait_n(vdp_wait_n),
        .vdp_reset_n(vdp_reset_n)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct packed {
        logic [7:0] b;
        logic       ctl;
        logic       rd;
        logic       setw;
        logic       wv;
    } mop_t;

    mop_t mq[$];
    int   m_rcnt = 0;
    int   m_phase = 0;  // 0 idle, 1 strobe, 2 gap
    int   m_cnt = 0;
    bit   m_wait_en = 0;
    bit   m_fix = 0;
    logic [7:0] m_fix_val = 0;
    bit   m_rdv = 0;
    logic [7:0] m_rdd = 0;

    function automatic mop_t mk(input logic [7:0] b, input bit ctl, input bit rd,
                                input bit setw, input bit wv);
        mop_t o;
        o.b = b; o.ctl = ctl; o.rd = rd; o.setw = setw; o.wv = wv;
        return o;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_rcnt = 0; m_phase = 0; m_cnt = 0; m_wait_en = 0;
            m_fix = 0; m_rdv = 0; m_rdd = 0;
        end else begin
            m_rdv = 0;
            case (m_phase)
                0: if (m_rcnt >= RESET_C && req_valid) begin
                    case (req_op)
                        2'd0: begin
                            mq.push_back(mk(req_addr[7:0], 1, 0, 0, 0));
                            mq.push_back(mk({2'b01, req_addr[13:8]}, 1, 0, 0, 0));
                            mq.push_back(mk(req_data, 0, 0, 0, 0));
                        end
                        2'd1: begin
                            mq.push_back(mk(req_addr[7:0], 1, 0, 0, 0));
                            mq.push_back(mk({2'b00, req_addr[13:8]}, 1, 0, 0, 0));
                            mq.push_back(mk(8'h00, 0, 1, 0, 0));
                        end
                        2'd2: begin
                            mq.push_back(mk(req_data, 1, 0, 0, 0));
                            mq.push_back(mk({2'b10, req_addr[5:0]}, 1, 0,
                                            req_addr[5:0] == 6'd25, req_data[2]));
                            if (guard_en && req_user && req_addr[5:0] == 6'd1 && !req_data[5]) begin
                                m_fix = 1;
                                m_fix_val = req_data | 8'h20;
                            end
                        end
                        default: mq.push_back(mk(8'h00, 1, 1, 0, 0));
                    endcase
                    m_phase = 1;
                    m_cnt = STROBE_C;
                end
                1: if (!(m_wait_en && !vdp_wait_n)) begin
                    m_cnt--;
                    if (m_cnt == 0) begin
                        if (mq[0].rd) begin
                            m_rdv = 1;
                            m_rdd = vdp_din;
                        end
                        if (mq[0].setw) m_wait_en = mq[0].wv;
                        m_cnt = mq[0].ctl ? SHORT_C : LONG_C;
                        m_phase = 2;
                    end
                end
                default: begin
                    m_cnt--;
                    if (m_cnt == 0) begin
                        void'(mq.pop_front());
                        if (mq.size() != 0) begin
                            m_phase = 1; m_cnt = STROBE_C;
                        end else if (m_fix) begin
                            mq.push_back(mk(m_fix_val, 1, 0, 0, 0));
                            mq.push_back(mk(8'h81, 1, 0, 0, 0));
                            m_fix = 0;
                            m_phase = 1; m_cnt = STROBE_C;
                        end else begin
                            m_phase = 0;
                        end
                    end
                end
            endcase
            if (m_rcnt < RESET_C) m_rcnt++;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            bit e_ready, e_csw, e_csr, e_rst;
            e_rst   = rst_n && (m_rcnt >= RESET_C);
            e_ready = e_rst && (m_phase == 0);
            e_csw   = !(m_phase == 1 && !mq[0].rd);
            e_csr   = !(m_phase == 1 && mq[0].rd);
            chk(vdp_reset_n === e_rst, "R1 vdp_reset_n", vdp_reset_n, e_rst);
            chk(req_ready === e_ready, "R7/R8 req_ready", req_ready, e_ready);
            chk(vdp_csw_n === e_csw, "R6/R7 vdp_csw_n", vdp_csw_n, e_csw);
            chk(vdp_csr_n === e_csr, "R6/R7 vdp_csr_n", vdp_csr_n, e_csr);
            if (m_phase == 1) begin
                chk(vdp_mode === mq[0].ctl, "R2/R4 vdp_mode", vdp_mode, mq[0].ctl);
                if (!mq[0].rd)
                    chk(vdp_dout === mq[0].b, "R2/R4 vdp_dout", vdp_dout, mq[0].b);
            end
            chk(rd_valid === m_rdv, "R11 rd_valid", rd_valid, m_rdv);
            if (m_rdv) chk(rd_data === m_rdd, "R3 rd_data", rd_data, m_rdd);
        end
    end

    // ---------------- behavioural device model ----------------
    logic [7:0] dev_reg [64];
    bit         dev_latch = 0;
    logic [7:0] dev_first = 0;
    logic [13:0] dev_addr = 0;
    bit         dev_wmode = 0;
    logic [7:0] dev_last_data = 0;
    int         dev_ctl_wr = 0;
    int         dev_ctl_rd = 0;
    int         dev_data_rd = 0;
    logic       prev_csw = 1, prev_csr = 1;
    int         cur_len = 0, last_len = 0;
    int         rd_seen = 0;
    logic [7:0] rd_got = 0;

    always @(negedge clk) begin
        if (rst_n && !vdp_csw_n && prev_csw) begin
            if (vdp_mode) begin
                dev_ctl_wr++;
                if (!dev_latch) begin
                    dev_first = vdp_dout; dev_latch = 1;
                end else begin
                    dev_latch = 0;
                    if (vdp_dout[7]) dev_reg[vdp_dout[5:0]] = dev_first;
                    else begin
                        dev_addr = {vdp_dout[5:0], dev_first};
                        dev_wmode = vdp_dout[6];
                    end
                end
            end else begin
                dev_last_data = vdp_dout;
            end
        end
        if (rst_n && !vdp_csr_n && prev_csr) begin
            if (vdp_mode) begin dev_ctl_rd++; dev_latch = 0; end
            else dev_data_rd++;
        end
        prev_csw = vdp_csw_n;
        prev_csr = vdp_csr_n;
        if (!vdp_csw_n || !vdp_csr_n) cur_len++;
        else if (cur_len != 0) begin last_len = cur_len; cur_len = 0; end
        if (rd_valid) begin rd_seen++; rd_got = rd_data; end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic [1:0] op, input logic [13:0] a,
                         input logic [7:0] dt, input bit user);
        while (req_ready !== 1'b1) @(negedge clk);
        req_valid = 1; req_op = op; req_addr = a; req_data = dt; req_user = user;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic finish_req();
        while (req_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_req(input logic [1:0] op, input logic [13:0] a,
                          input logic [7:0] dt, input bit user);
        issue(op, a, dt, user);
        finish_req();
    endtask

    initial begin
        int w0, r0;
        repeat (5) @(negedge clk);
        chk(vdp_reset_n === 1'b0, "R1 reset low in reset", vdp_reset_n, 0);
        chk(req_ready === 1'b0, "R1 ready low in reset", req_ready, 0);
        rst_n = 1;
        repeat (RESET_C - 1) @(negedge clk);
        chk(vdp_reset_n === 1'b0, "R1 reset low before edge RESET_C", vdp_reset_n, 0);
        @(negedge clk);
        chk(vdp_reset_n === 1'b1, "R1 reset high after edge RESET_C", vdp_reset_n, 1);

        // R4 register write
        w0 = dev_ctl_wr;
        do_req(2'd2, 14'd7, 8'h42, 0);
        chk(dev_reg[7] === 8'h42, "R4 reg7 value", dev_reg[7], 8'h42);
        chk(dev_ctl_wr - w0 == 2, "R4 two control writes", dev_ctl_wr - w0, 2);
        do_req(2'd2, 14'd14, 8'h07, 0);
        chk(dev_reg[14] === 8'h07, "R4 reg14 value", dev_reg[14], 8'h07);

        // R2 VRAM write
        do_req(2'd0, 14'h1234, 8'hA5, 0);
        chk(dev_addr === 14'h1234, "R2 vram address", dev_addr, 14'h1234);
        chk(dev_wmode === 1'b1, "R2 write-mode bit", dev_wmode, 1);
        chk(dev_last_data === 8'hA5, "R2 data byte", dev_last_data, 8'hA5);

        // R3 VRAM read
        vdp_din = 8'h5A;
        r0 = rd_seen;
        do_req(2'd1, 14'h0ABC, 8'h00, 0);
        chk(dev_addr === 14'h0ABC, "R3 vram address", dev_addr, 14'h0ABC);
        chk(dev_wmode === 1'b0, "R3 read-mode bit", dev_wmode, 0);
        chk(rd_got === 8'h5A, "R3 read data", rd_got, 8'h5A);
        chk(rd_seen - r0 == 1, "R11 one pulse per read", rd_seen - r0, 1);

        // R5 status read
        vdp_din = 8'h9F;
        w0 = dev_ctl_wr; r0 = dev_ctl_rd;
        do_req(2'd3, 14'd0, 8'h00, 0);
        chk(dev_ctl_wr == w0, "R5 no write strobe", dev_ctl_wr - w0, 0);
        chk(dev_ctl_rd - r0 == 1, "R5 one control read", dev_ctl_rd - r0, 1);
        chk(rd_got === 8'h9F, "R5 status data", rd_got, 8'h9F);
        chk(last_len == STROBE_C, "R6 strobe width", last_len, STROBE_C);

        // R9 wait disabled: vdp_wait_n ignored
        vdp_wait_n = 0;
        issue(2'd3, 14'd0, 8'h00, 0);
        repeat (12) @(negedge clk);
        vdp_wait_n = 1;
        finish_req();
        chk(last_len == STROBE_C, "R9 wait ignored when disabled", last_len, STROBE_C);

        // R9 wait enabled through register 25 bit 2
        do_req(2'd2, 14'd25, 8'h04, 0);
        vdp_wait_n = 0;
        issue(2'd3, 14'd0, 8'h00, 0);
        repeat (12) @(negedge clk);
        vdp_wait_n = 1;
        finish_req();
        chk(last_len > STROBE_C, "R9 strobe stretched by wait", last_len, STROBE_C + 1);
        do_req(2'd2, 14'd25, 8'h00, 0);

        // R10 guard mode
        guard_en = 1;
        w0 = dev_ctl_wr;
        do_req(2'd2, 14'd1, 8'h00, 1);
        chk(dev_reg[1] === 8'h20, "R10 interrupt bit restored", dev_reg[1], 8'h20);
        chk(dev_ctl_wr - w0 == 4, "R10 restore write added", dev_ctl_wr - w0, 4);
        w0 = dev_ctl_wr;
        do_req(2'd2, 14'd1, 8'h00, 0);
        chk(dev_reg[1] === 8'h00, "R10 supervisor write untouched", dev_reg[1], 8'h00);
        chk(dev_ctl_wr - w0 == 2, "R10 no restore for supervisor", dev_ctl_wr - w0, 2);
        w0 = dev_ctl_wr;
        do_req(2'd2, 14'd1, 8'h60, 1);
        chk(dev_reg[1] === 8'h60, "R10 bit already set", dev_reg[1], 8'h60);
        chk(dev_ctl_wr - w0 == 2, "R10 no restore when bit set", dev_ctl_wr - w0, 2);
        guard_en = 0;
        w0 = dev_ctl_wr;
        do_req(2'd2, 14'd1, 8'h00, 1);
        chk(dev_reg[1] === 8'h00, "R10 guard off", dev_reg[1], 8'h00);
        chk(dev_ctl_wr - w0 == 2, "R10 no restore with guard off", dev_ctl_wr - w0, 2);

        // back-to-back requests, ready held then released (R8)
        do_req(2'd0, 14'h3FFF, 8'h11, 0);
        chk(dev_addr === 14'h3FFF, "R2 top address", dev_addr, 14'h3FFF);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 150000 && !finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected 0", wd);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule